// File: doc/BRIEF.md
# Shared Multi-Queue Input Buffer

This block is the flit store at one input port of an on-chip network router. A single array of entries is shared by every output direction. Each output direction sees its own first-in first-out queue, built as a chain of entries linked through a per-entry next-index field. An arriving flit carries the number of the output it is bound for. The block takes a free entry, writes the flit there and appends that entry to the tail of the chain for that output.

Each output has its own dequeue request. The block always presents the oldest flit of every non-empty queue on that output's data lane. When a request is made against a non-empty queue, the head entry leaves the chain and returns to the pool at the next clock edge. A queue whose output is stalled keeps its flits, and the flits bound for the other outputs still move. Any one queue may grow to fill the whole array. Route computation, the crossbar and arbitration between inputs are handled elsewhere.

Top module: `mq_input_buffer`

## Requirements
- R1: After reset every queue reports empty (`q_empty` all ones) and `full` is low.
- R2: A write accepted for output d makes `q_empty[d]` low in the next cycle. When queue d was empty, the lane of d (bits d*16 +: 16 of `head_data`) then shows the written flit.
- R3: Each queue delivers its flits in the order in which they were written. A flit is consumed only by a cycle where that queue's bit of `deq_req` is high and the queue is not empty.
- R4: Queues are independent. A queue that is not being read keeps its head flit while other queues are written and read, and the other queues keep moving. This means there is no head-of-line blocking.
- R5: With 16 entries, any one queue can hold all 16 flits. `full` is high exactly when all 16 entries are occupied.
- R6: A write in a cycle where `full` is high and no dequeue takes place is ignored. It does not change the state of any queue.
- R7: When the buffer is full, a write and a dequeue in the same cycle both succeed, and the freed entry is reused at once.
- R8: A dequeue request on an empty queue has no effect.
- R9: Several queues can dequeue in the same cycle, and every entry freed that way becomes available again.
- R10: Entries are recycled without loss. Over any long mix of writes and reads, the number of free entries plus the number of queued flits stays 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A flit is offered for storage |
| wr_dest | input | 2 | Output queue number of the offered flit |
| wr_flit | input | 16 | Offered flit |
| full | output | 1 | No free entry remains |
| deq_req | input | 4 | Per-output request to consume the head flit |
| head_data | output | 64 | Head flit of each queue, queue q on bits q*16 +: 16 |
| q_empty | output | 4 | Per-queue empty flag |

## Verification
Some behaviour is checked by assertions on every cycle. Each accepted write must land at the tail of its queue. An untouched queue must keep its pointers. A released entry must be one that was in use, and no two releases in the same cycle may name the same entry. An ignored write while full must leave every empty flag as it was. Ordering, the absence of head-of-line blocking, full-buffer reuse and entry recycling depend on long sequences of traffic. Those can only be shown by the bench scenarios, which compare every lane against a separate FIFO per output on every cycle.

// File: rtl/mq_pkg.sv
package mq_pkg;
   localparam int unsigned MQ_DEF_DEPTH  = 16;
   localparam int unsigned MQ_DEF_QUEUES = 4;
   localparam int unsigned MQ_DEF_WIDTH  = 16;
endpackage

// File: rtl/mq_free_pool.sv
module mq_free_pool #(
   parameter int unsigned DEPTH = mq_pkg::MQ_DEF_DEPTH,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] release_mask,
   input  logic             take,
   output logic [AW-1:0]    take_idx,
   output logic             take_ok,
   output logic             pool_empty
);
   logic [DEPTH-1:0] free_q;
   logic [DEPTH-1:0] cand;
   logic [DEPTH-1:0] take_mask;

   // entries freed this cycle may be handed out in the same cycle
   assign cand    = free_q | release_mask;
   assign take_ok = |cand;
   assign pool_empty = ~|free_q;

   always_comb begin
      take_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (cand[i]) take_idx = AW'(i);
      end
   end

   always_comb begin
      take_mask = '0;
      if (take && take_ok) take_mask[take_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) free_q <= '1;
      else        free_q <= cand & ~take_mask;
   end

   // R10
   release_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (release_mask & free_q) == '0);
endmodule

// File: rtl/mq_entry_store.sv
module mq_entry_store #(
   parameter int unsigned DEPTH  = mq_pkg::MQ_DEF_DEPTH,
   parameter int unsigned QUEUES = mq_pkg::MQ_DEF_QUEUES,
   parameter int unsigned WIDTH  = mq_pkg::MQ_DEF_WIDTH,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    data_we,
   input  logic [AW-1:0]           data_addr,
   input  logic [WIDTH-1:0]        data_in,
   input  logic                    link_we,
   input  logic [AW-1:0]           link_addr,
   input  logic [AW-1:0]           link_val,
   input  logic [QUEUES*AW-1:0]    rd_addr,
   output logic [QUEUES*WIDTH-1:0] rd_data,
   output logic [QUEUES*AW-1:0]    rd_link
);
   logic [WIDTH-1:0] data_mem [DEPTH];
   logic [AW-1:0]    link_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (data_we) data_mem[data_addr] <= data_in;
      if (link_we) link_mem[link_addr] <= link_val;
   end

   for (genvar q = 0; q < QUEUES; q++) begin : g_port
      assign rd_data[q*WIDTH +: WIDTH] = data_mem[rd_addr[q*AW +: AW]];
      assign rd_link[q*AW +: AW]       = link_mem[rd_addr[q*AW +: AW]];
   end
endmodule

// File: rtl/mq_queue_ctrl.sv
module mq_queue_ctrl #(
   parameter int unsigned DEPTH = mq_pkg::MQ_DEF_DEPTH,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enq,
   input  logic          deq_req,
   input  logic [AW-1:0] alloc_idx,
   input  logic [AW-1:0] head_next,
   output logic [AW-1:0] head,
   output logic [AW-1:0] tail,
   output logic          live,
   output logic          deq,
   output logic          link_we
);
   logic single;

   assign single  = (head == tail);
   assign deq     = deq_req & live;
   assign link_we = enq & live & ~(deq & single);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         live <= 1'b0;
      end else if (enq && deq) begin
         head <= single ? alloc_idx : head_next;
         tail <= alloc_idx;
      end else if (enq) begin
         if (!live) head <= alloc_idx;
         tail <= alloc_idx;
         live <= 1'b1;
      end else if (deq) begin
         if (single) live <= 1'b0;
         else        head <= head_next;
      end
   end

   // R2
   enq_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enq |=> (live && tail == $past(alloc_idx)));
   // R4
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enq && !deq) |=> ($stable(head) && $stable(tail) && $stable(live)));
endmodule

// File: rtl/mq_input_buffer.sv
module mq_input_buffer #(
   parameter int unsigned DEPTH  = mq_pkg::MQ_DEF_DEPTH,
   parameter int unsigned QUEUES = mq_pkg::MQ_DEF_QUEUES,
   parameter int unsigned WIDTH  = mq_pkg::MQ_DEF_WIDTH,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned QW = $clog2(QUEUES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_valid,
   input  logic [QW-1:0]           wr_dest,
   input  logic [WIDTH-1:0]        wr_flit,
   output logic                    full,
   input  logic [QUEUES-1:0]       deq_req,
   output logic [QUEUES*WIDTH-1:0] head_data,
   output logic [QUEUES-1:0]       q_empty
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (QUEUES < 2 || (1 << QW) != QUEUES) begin : g_bad_queues
      $error("QUEUES must be a power of two of at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("WIDTH must be positive");
   end

   logic [AW-1:0]        alloc_idx;
   logic                 alloc_ok;
   logic                 wr_take;
   logic [DEPTH-1:0]     rel_mask;
   logic [QUEUES-1:0]    deq_vec;
   logic [QUEUES-1:0]    link_vec;
   logic [QUEUES-1:0]    live_vec;
   logic [QUEUES*AW-1:0] heads;
   logic [QUEUES*AW-1:0] tails;
   logic [QUEUES*AW-1:0] head_links;
   logic                 link_we;
   logic [AW-1:0]        link_addr;

   assign wr_take   = wr_valid & alloc_ok;
   assign link_we   = |link_vec;
   assign link_addr = tails[wr_dest*AW +: AW];
   assign q_empty   = ~live_vec;

   always_comb begin
      rel_mask = '0;
      for (int q = 0; q < QUEUES; q++) begin
         if (deq_vec[q]) rel_mask[heads[q*AW +: AW]] = 1'b1;
      end
   end

   mq_free_pool #(.DEPTH(DEPTH)) u_pool (
      .clk          (clk),
      .rst_n        (rst_n),
      .release_mask (rel_mask),
      .take         (wr_valid),
      .take_idx     (alloc_idx),
      .take_ok      (alloc_ok),
      .pool_empty   (full)
   );

   mq_entry_store #(.DEPTH(DEPTH), .QUEUES(QUEUES), .WIDTH(WIDTH)) u_store (
      .clk       (clk),
      .data_we   (wr_take),
      .data_addr (alloc_idx),
      .data_in   (wr_flit),
      .link_we   (link_we),
      .link_addr (link_addr),
      .link_val  (alloc_idx),
      .rd_addr   (heads),
      .rd_data   (head_data),
      .rd_link   (head_links)
   );

   for (genvar q = 0; q < QUEUES; q++) begin : g_queue
      logic enq_q;
      assign enq_q = wr_take & (wr_dest == QW'(q));
      mq_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .enq       (enq_q),
         .deq_req   (deq_req[q]),
         .alloc_idx (alloc_idx),
         .head_next (head_links[q*AW +: AW]),
         .head      (heads[q*AW +: AW]),
         .tail      (tails[q*AW +: AW]),
         .live      (live_vec[q]),
         .deq       (deq_vec[q]),
         .link_we   (link_vec[q])
      );
   end

   // R6
   full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_valid && deq_vec == '0) |=> $stable(q_empty));
   // R9
   distinct_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rel_mask) == $countones(deq_vec));
endmodule

// File: tb/test_mq_input_buffer.sv
`timescale 1ns/1ps
module test_mq_input_buffer;
   localparam int NQ = 4;
   localparam int DP = 16;
   localparam int W  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [1:0]    wr_dest = '0;
   logic [W-1:0]  wr_flit = '0;
   logic          full;
   logic [NQ-1:0] deq_req = '0;
   logic [NQ*W-1:0] head_data;
   logic [NQ-1:0] q_empty;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] mq [NQ][DP];
   int mhd [NQ];
   int mcnt [NQ];

   always #4 clk = ~clk;

   mq_input_buffer i_mq_input_buffer (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_dest(wr_dest),
      .wr_flit(wr_flit), .full(full), .deq_req(deq_req),
      .head_data(head_data), .q_empty(q_empty)
   );

   function automatic int total();
      int t = 0;
      for (int q = 0; q < NQ; q++) t += mcnt[q];
      return t;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // compare all outputs with the per-output FIFO model
   task automatic compare(input string tag);
      chk(full == (total() == DP), {tag, " full"}, full, total() == DP);
      for (int q = 0; q < NQ; q++) begin
         chk(q_empty[q] == (mcnt[q] == 0), {tag, " empty"}, q_empty[q], mcnt[q] == 0);
         if (mcnt[q] != 0)
            chk(head_data[q*W +: W] == mq[q][mhd[q]], {tag, " head"},
                head_data[q*W +: W], mq[q][mhd[q]]);
      end
   endtask

   task automatic step(input bit wv, input int d, input logic [W-1:0] dat,
                       input logic [NQ-1:0] rq, input string tag);
      int ndeq = 0;
      bit room;
      compare(tag);
      wr_valid = wv; wr_dest = 2'(d); wr_flit = dat; deq_req = rq;
      room = (total() < DP);
      for (int q = 0; q < NQ; q++) begin
         if (rq[q] && mcnt[q] > 0) begin
            mhd[q] = (mhd[q] + 1) % DP;
            mcnt[q]--;
            ndeq++;
         end
      end
      if (wv && (room || ndeq > 0)) begin
         mq[d][(mhd[d] + mcnt[d]) % DP] = dat;
         mcnt[d]++;
      end
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0; deq_req = '0;
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      for (int q = 0; q < NQ; q++) begin mhd[q] = 0; mcnt[q] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(q_empty == 4'hF, "R1 empty after reset", q_empty, 4'hF);
      chk(full == 1'b0, "R1 full after reset", full, 0);

      // R2 first write to an empty queue becomes its head
      step(1, 1, 16'h1111, 4'h0, "R2");
      compare("R2");
      // R8 read of empty queues ignored
      step(0, 0, 0, 4'b1101, "R8");
      compare("R8");
      step(1, 1, 16'h1112, 4'h0, "R3");
      step(0, 0, 0, 4'b0010, "R3");
      step(0, 0, 0, 4'b0010, "R3");

      // R5 one queue fills the whole array
      for (int i = 0; i < DP; i++) step(1, 2, 16'h2000 + 16'(i), 4'h0, "R5");
      chk(full == 1'b1, "R5 full after 16 writes", full, 1);
      // R6 write while full ignored
      step(1, 3, 16'hDEAD, 4'h0, "R6");
      chk(q_empty[3] == 1'b1, "R6 ignored write", q_empty[3], 1);
      // R7 write and read together while full
      step(1, 0, 16'h0A0A, 4'b0100, "R7");
      chk(full == 1'b1 && q_empty[0] == 1'b0, "R7 both succeed", {full, q_empty[0]}, 2'b10);
      step(1, 2, 16'h2FFF, 4'b0001, "R7");
      compare("R7");

      // R4 queue 2 stalled while queues 1 and 3 move
      for (int i = 0; i < 6; i++) begin
         step(0, 0, 0, 4'b0100, "R4 drain");
      end
      for (int i = 0; i < 20; i++)
         step(1, (i % 2) ? 3 : 1, 16'h3000 + 16'(i), (i > 1) ? 4'b1010 : 4'b0000, "R4");
      compare("R4");

      // R9 several queues read in one cycle
      step(1, 0, 16'h4444, 4'h0, "R9");
      step(1, 1, 16'h5555, 4'h0, "R9");
      step(1, 3, 16'h6666, 4'h0, "R9");
      step(0, 0, 0, 4'b1111, "R9");
      compare("R9");
      for (int i = 0; i < 20; i++) step(0, 0, 0, 4'b1111, "R9 drain");
      chk(q_empty == 4'hF && full == 1'b0, "R9 all drained", {q_empty, full}, 5'h1E);

      // R3 and R10 random sweep with recycling
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] rq;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rq = (i % 400 < 200) ? (lfsr[3:0] & lfsr[7:4]) : (lfsr[3:0] | lfsr[11:8]);
         step(lfsr[9] | lfsr[14], int'(lfsr[13:12]), lfsr ^ 16'(i), rq, "R3 R10 sweep");
      end
      for (int i = 0; i < 20; i++) step(0, 0, 0, 4'b1111, "R10 drain");
      chk(q_empty == 4'hF && full == 1'b0, "R10 no entry lost", {q_empty, full}, 5'h1E);
      for (int i = 0; i < DP; i++) step(1, i % NQ, 16'h7000 + 16'(i), 4'h0, "R10 refill");
      chk(full == 1'b1, "R10 all 16 reusable", full, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule